// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block is a purely combinational 16-bit adder. It takes two operands and a carry input and returns a 16-bit sum and a carry output. The operand bits are divided into four slices of four bits. Each slice works out its own carries by lookahead from per-bit generate and propagate terms. Each slice also summarises itself as one slice-propagate bit and one slice-generate bit.

A second lookahead unit takes those slice summaries and the carry input. It forms the carry into every slice, and the final carry out, all in parallel. No carry ripples from one slice to the next. The block sits in a datapath wherever a fast single-cycle add is needed, and it has no state.

Top module: `cla_adder16`

## Requirements
- R1: For every input, {carry_o, sum_o} equals the 17-bit unsigned value a_i + b_i + carry_i.
- R2: With a_i = 16'hFFFF, b_i = 16'h0000 and carry_i = 1, the carry passes through all four slices, giving sum_o = 16'h0000 and carry_o = 1.
- R3: A slice in which every bit has exactly one operand bit set passes its carry-in unchanged to the next slice. For example, a_i = 16'h0FFF, b_i = 16'h0001 and carry_i = 0 give sum_o = 16'h1000 and carry_o = 0.
- R4: A slice that generates a carry delivers a 1 to the next slice whatever its own carry-in is. A slice generates when some bit has both operand bits set and every higher bit of that slice propagates. For example, a_i = b_i = 16'h0008 gives sum_o = 16'h0010.
- R5: Zero operands with carry_i = 0 give sum_o = 0 and carry_o = 0.
- R6: The carry the second-level unit gives each slice equals the carry-out that the slice below computes from its own bits. This holds over random operands, where a mismatch would break R1.
- R7: With no bit position set in both operands and carry_i = 0, no carry is produced: sum_o = a_i | b_i and carry_o = 0.
- R8: The largest input, 16'hFFFF + 16'hFFFF + 1, gives sum_o = 16'hFFFF and carry_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| carry_o | output | 1 | Carry out of bit 15 |

## Verification
The block holds no state, so a wrong slice summary or a wrong second-level carry shows up at once. It appears in the same evaluation as the input change, as a wrong sum in the four bits above the faulty slice boundary, or as a wrong carry_o. Patterns that make one slice propagate and the slice below it generate expose a bad slice-propagate or slice-generate term. Full-propagation patterns expose a broken carry input term. Random operands cover mixed cases where slice carries disagree with their internal lookahead.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned DEF_WIDTH = 16;
  localparam int unsigned DEF_GRP_W = 4;
endpackage

// File: rtl/cla_lookahead.sv
// Flat sum-of-products carry unit over N generate/propagate pairs
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:0]   carry_o,
  output logic         blk_prop_o,
  output logic         blk_gen_o
);
  always_comb begin
    carry_o[0] = cin_i;
    for (int j = 1; j <= int'(N); j++) begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int k = 0; k < j; k++) begin
        term = gen_i[k];
        for (int m = k + 1; m < j; m++) term = term & prop_i[m];
        acc = acc | term;
      end
      term = cin_i;
      for (int m = 0; m < j; m++) term = term & prop_i[m];
      carry_o[j] = acc | term;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      term = gen_i[k];
      for (int m = k + 1; m < int'(N); m++) term = term & prop_i[m];
      acc = acc | term;
    end
    blk_gen_o  = acc;
    blk_prop_o = &prop_i;
  end
endmodule

// File: rtl/cla_group.sv
// One slice: bit g/p, internal lookahead, sum bits, slice summary
module cla_group #(
  parameter int unsigned GRP_W = 4
) (
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  input  logic             cin_i,
  output logic [GRP_W-1:0] sum_o,
  output logic             grp_prop_o,
  output logic             grp_gen_o,
  output logic             grp_cout_o
);
  logic [GRP_W-1:0] bit_gen;
  logic [GRP_W-1:0] bit_prop;
  logic [GRP_W:0]   bit_carry;

  assign bit_gen  = a_i & b_i;
  assign bit_prop = a_i | b_i;

  cla_lookahead #(.N(GRP_W)) u_la (
    .gen_i      (bit_gen),
    .prop_i     (bit_prop),
    .cin_i      (cin_i),
    .carry_o    (bit_carry),
    .blk_prop_o (grp_prop_o),
    .blk_gen_o  (grp_gen_o)
  );

  assign sum_o      = a_i ^ b_i ^ bit_carry[GRP_W-1:0];
  assign grp_cout_o = bit_carry[GRP_W];
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int unsigned WIDTH = cla_pkg::DEF_WIDTH,
  parameter int unsigned GRP_W = cla_pkg::DEF_GRP_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int unsigned N_GRP = WIDTH / GRP_W;

  logic [N_GRP-1:0] grp_prop;
  logic [N_GRP-1:0] grp_gen;
  logic [N_GRP-1:0] grp_cout;
  logic [N_GRP:0]   grp_carry;
  logic             top_prop;
  logic             top_gen;

  // second level: all slice carries in parallel
  cla_lookahead #(.N(N_GRP)) u_level2 (
    .gen_i      (grp_gen),
    .prop_i     (grp_prop),
    .cin_i      (carry_i),
    .carry_o    (grp_carry),
    .blk_prop_o (top_prop),
    .blk_gen_o  (top_gen)
  );

  for (genvar k = 0; k < int'(N_GRP); k++) begin : g_slice
    cla_group #(.GRP_W(GRP_W)) u_grp (
      .a_i        (a_i[k*GRP_W +: GRP_W]),
      .b_i        (b_i[k*GRP_W +: GRP_W]),
      .cin_i      (grp_carry[k]),
      .sum_o      (sum_o[k*GRP_W +: GRP_W]),
      .grp_prop_o (grp_prop[k]),
      .grp_gen_o  (grp_gen[k]),
      .grp_cout_o (grp_cout[k])
    );
  end

  assign carry_o = grp_carry[N_GRP];
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned N_GRP = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic [N_GRP-1:0] grp_prop,
  input logic [N_GRP-1:0] grp_gen,
  input logic [N_GRP-1:0] grp_cout,
  input logic [N_GRP:0]   grp_carry,
  input logic             top_prop,
  input logic             top_gen
);
  always_comb begin
    assert_sum_matches_R1: assert ({carry_o, sum_o} ==
      ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}));
    for (int k = 0; k < int'(N_GRP); k++) begin
      assert_slice_carry_agree_R6: assert (grp_carry[k+1] == grp_cout[k]);
      assert_slice_gen_R4: assert (!grp_gen[k] || grp_carry[k+1]);
      assert_slice_pass_R3: assert (!(grp_prop[k] && !grp_gen[k]) ||
                                    (grp_carry[k+1] == grp_carry[k]));
    end
    assert_top_gen_R4: assert (!top_gen || carry_o);
    assert_full_pass_R2: assert (!(top_prop && !top_gen) || (carry_o == carry_i));
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.WIDTH(WIDTH), .N_GRP(N_GRP)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .carry_i   (carry_i),
  .sum_o     (sum_o),
  .carry_o   (carry_o),
  .grp_prop  (grp_prop),
  .grp_gen   (grp_gen),
  .grp_cout  (grp_cout),
  .grp_carry (grp_carry),
  .top_prop  (top_prop),
  .top_gen   (top_gen)
);

// File: tb/sim_cla_adder16.sv
`timescale 1ns/1ps
module sim_cla_adder16;
  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    logic [16:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic        carry_i = 1'b0;
  logic [15:0] sum_o;
  logic        carry_o;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cla_adder16 u0 (
    .a_i     (a_i),
    .b_i     (b_i),
    .carry_i (carry_i),
    .sum_o   (sum_o),
    .carry_o (carry_o)
  );

  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic cin, input string req);
    item_t it;
    @(negedge clk);
    a_i = a; b_i = b; carry_i = cin;
    it.a = a; it.b = b; it.cin = cin; it.req = req;
    it.exp = {1'b0, a} + {1'b0, b} + {16'd0, cin};
    q.push_back(it);
  endtask

  // monitor: compare at the next rising edge
  always @(posedge clk) begin
    if (rst_ni && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ({carry_o, sum_o} !== it.exp) begin
        errors++;
        $display("FAIL %s a=%h b=%h cin=%0b actual=%h expected=%h",
                 it.req, it.a, it.b, it.cin, {carry_o, sum_o}, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R5: reset-time state, zero inputs
    repeat (2) @(negedge clk);
    checks++;
    if ({carry_o, sum_o} !== 17'h0) begin
      errors++;
      $display("FAIL R5 actual=%h expected=%h", {carry_o, sum_o}, 17'h0);
    end
    rst_ni = 1'b1;
    drive(16'h0000, 16'h0000, 1'b0, "R5");
    drive(16'hFFFF, 16'h0000, 1'b1, "R2");
    drive(16'h0000, 16'hFFFF, 1'b1, "R2");
    drive(16'h0FFF, 16'h0001, 1'b0, "R3");
    drive(16'h00F0, 16'h000F, 1'b1, "R3");
    drive(16'hF0F0, 16'h0F0F, 1'b0, "R3");
    drive(16'h0008, 16'h0008, 1'b0, "R4");
    drive(16'h8800, 16'h8800, 1'b0, "R4");
    drive(16'h0080, 16'h0080, 1'b1, "R4");
    drive(16'hA5A5, 16'h5A5A, 1'b0, "R7");
    drive(16'h1234, 16'h4002, 1'b0, "R7");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R8");
    drive(16'hFFFF, 16'hFFFF, 1'b0, "R8");
    // single-bit carry injected at each slice boundary
    for (int k = 0; k < 16; k++) begin
      drive(16'hFFFF >> k, 16'h0001 << (15 - k), 1'b0, "R3");
      drive(16'h0001 << k, 16'h0001 << k, 1'b1, "R4");
    end
    // R6 and R1: random mixtures of slice carries
    for (int i = 0; i < 3000; i++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom), "R1");
    end
    for (int i = 0; i < 500; i++) begin
      drive(16'($urandom) | 16'hF0F0, 16'($urandom) & 16'h0F0F,
            1'($urandom), "R6");
    end
    while (q.size() > 0) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule